// File: doc/BRIEF.md
# Single-Bus ALU Datapath

This block is the 32-bit datapath of a small processor built around one shared bus. One source drives the bus each cycle. It can be a control-word constant, the operand register Y, the result register Z, the program counter or a register-file entry. It can also be one of three values taken from the instruction register: the immediate, the branch offset or the jump target. Any number of storage elements can capture the bus value at the closing clock edge of that cycle. An external sequencer supplies a one-hot source vector, the load strobes, the ALU operation and a field selector in every cycle. That sequencer and the memory system are outside this block.

Because there is only one bus, Y always supplies one ALU operand and the bus supplies the other. The ALU output is captured only when Z is loaded. The register file is addressed only through fields of the instruction register. The selector picks which field applies, so no register number ever comes from the control word. Entry 0 of the register file is hard-wired to zero.

Top module: `sbd_top`

## Requirements
- R1: The bus equals the value of the one source whose bit is set in `src_en`. The bit positions are: 0 constant, 1 Y, 2 Z, 3 PC, 4 register file, 5 immediate, 6 branch offset, 7 jump target. With no bit set the bus reads zero. Setting two or more bits is a caller error that an assertion flags.
- R2: ALU code 0 computes Y plus the bus. Code 7 computes Y minus the bus. Both wrap modulo 2^32.
- R3: ALU code 1 computes the bitwise AND of Y and the bus. Code 2 computes XOR and code 3 computes OR.
- R4: ALU code 4 shifts the bus value left, and code 5 shifts it right logically. In both cases the shift distance is Y[4:0].
- R5: ALU code 6 gives 1 when Y is less than the bus value as signed two's-complement numbers, and 0 otherwise.
- R6: Y captures the bus at the clock edge only when `ld_y` is high. Z captures the ALU result only when `ld_z` is high. Otherwise each keeps its value.
- R7: The immediate source drives IR[15:0] sign-extended to 32 bits.
- R8: The branch-offset source drives IR[15:0] sign-extended to 32 bits and then shifted left by 2.
- R9: The jump-target source drives {PC[31:26], IR[25:0]}.
- R10: `ld_pc` loads the bus into PC unconditionally. `ld_pc_z` loads it only when Z is zero, and otherwise leaves PC unchanged.
- R11: `reg_sel` picks the register-file entry. Code 0 selects the entry named by IR[25:21], code 1 the entry named by IR[20:16], and codes 2 and 3 the entry named by IR[15:11]. The selected entry drives the bus and also receives the bus when `ld_reg` is high.
- R12: Register entry 0 always reads as zero, and a write to it has no effect.
- R13: Reset (`rst_n` low) clears Y, Z, PC, IR and every register entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_en | input | 8 | One-hot bus source enable |
| ld_y | input | 1 | Load Y from bus |
| ld_z | input | 1 | Load Z from ALU result |
| ld_pc | input | 1 | Load PC from bus |
| ld_pc_z | input | 1 | Load PC from bus if Z is zero |
| ld_ir | input | 1 | Load IR from bus |
| ld_reg | input | 1 | Write bus into selected register entry |
| alu_op | input | 3 | ALU operation code |
| reg_sel | input | 2 | Instruction field used to address the register file |
| const_val | input | 32 | Constant driven when source 0 is enabled |
| bus_o | output | 32 | Current bus value |
| pc_o | output | 32 | Program counter |
| z_o | output | 32 | Result register Z |

## Verification
The bench targets operand orientation first. If subtract, set-less-than or the shifts swapped Y and the bus, then 3-10, the shift of 0x80000000 by Y and the comparison -1 < 1 would all give wrong values. A set-less-than that compares unsigned would return 0 for -1 < 1. A shifter that decodes more than Y[4:0] would clear the result for Y = 0x21. The bench also checks the sign of the immediate and the offset with negative and positive fields. It checks that the top six PC bits are merged into the jump target. It checks that a conditional PC load with nonzero Z is skipped, because a design that loaded anyway would move PC. Finally it checks that entry 0 stays zero after a write, and that reads and writes through the three IR fields reach the same entries.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
    localparam int DATA_W   = 32;
    localparam int REG_CNT  = 32;
    localparam int REG_AW   = $clog2(REG_CNT);
    localparam int SHAMT_W  = $clog2(DATA_W);
    localparam int IMM_W    = 16;
    localparam int JADDR_W  = 26;
    localparam int OFS_SH   = 2;
    localparam int RS_LSB   = 21;
    localparam int RT_LSB   = 16;
    localparam int RD_LSB   = 11;

    localparam int SRC_N     = 8;
    localparam int SRC_CONST = 0;
    localparam int SRC_Y     = 1;
    localparam int SRC_Z     = 2;
    localparam int SRC_PC    = 3;
    localparam int SRC_REG   = 4;
    localparam int SRC_IMM   = 5;
    localparam int SRC_OFS   = 6;
    localparam int SRC_JMP   = 7;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_AND = 3'd1,
        ALU_XOR = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLL = 3'd4,
        ALU_SRL = 3'd5,
        ALU_SLT = 3'd6,
        ALU_SUB = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        FLD_RS  = 2'd0,
        FLD_RT  = 2'd1,
        FLD_RD  = 2'd2,
        FLD_RD2 = 2'd3
    } fld_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] z;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] ir;
    } dp_regs_t;
endpackage

// File: rtl/sbd_alu.sv
module sbd_alu
    import sbd_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] bus_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] res_o
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] shamt;
    assign shamt = y_i[SW-1:0];

    always_comb begin
        unique case (op_i)
            ALU_ADD: res_o = y_i + bus_i;
            ALU_AND: res_o = y_i & bus_i;
            ALU_XOR: res_o = y_i ^ bus_i;
            ALU_OR:  res_o = y_i | bus_i;
            ALU_SLL: res_o = bus_i << shamt;
            ALU_SRL: res_o = bus_i >> shamt;
            ALU_SLT: res_o = {{(W-1){1'b0}}, ($signed(y_i) < $signed(bus_i))};
            ALU_SUB: res_o = y_i - bus_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/sbd_ir_fields.sv
module sbd_ir_fields
    import sbd_pkg::*;
(
    input  logic [DATA_W-1:0] ir_i,
    input  logic [DATA_W-1:0] pc_i,
    output logic [REG_AW-1:0] rs_o,
    output logic [REG_AW-1:0] rt_o,
    output logic [REG_AW-1:0] rd_o,
    output logic [DATA_W-1:0] imm_o,
    output logic [DATA_W-1:0] ofs_o,
    output logic [DATA_W-1:0] jmp_o
);
    localparam int PC_TOP = DATA_W - JADDR_W;

    logic [IMM_W-1:0] imm_raw;

    assign rs_o    = ir_i[RS_LSB +: REG_AW];
    assign rt_o    = ir_i[RT_LSB +: REG_AW];
    assign rd_o    = ir_i[RD_LSB +: REG_AW];
    assign imm_raw = ir_i[IMM_W-1:0];
    assign imm_o   = {{(DATA_W-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
    assign ofs_o   = imm_o << OFS_SH;
    assign jmp_o   = {pc_i[DATA_W-1 -: PC_TOP], ir_i[JADDR_W-1:0]};
endmodule

// File: rtl/sbd_regfile.sv
module sbd_regfile #(
    parameter int W   = 32,
    parameter int CNT = 32,
    localparam int AW = $clog2(CNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] idx_i,
    input  logic          we_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] ent_q [CNT];

    for (genvar g = 0; g < CNT; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign ent_q[g] = '0;
        end else begin : g_store
            logic [W-1:0] ent_d;
            always_comb begin
                ent_d = ent_q[g];
                if (we_i && (idx_i == AW'(g))) ent_d = wdata_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ent_q[g] <= '0;
                else        ent_q[g] <= ent_d;
            end
        end
    end

    assign rdata_o = ent_q[idx_i];
endmodule

// File: rtl/sbd_top.sv
module sbd_top
    import sbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_en,
    input  logic              ld_y,
    input  logic              ld_z,
    input  logic              ld_pc,
    input  logic              ld_pc_z,
    input  logic              ld_ir,
    input  logic              ld_reg,
    input  logic [2:0]        alu_op,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] const_val,
    output logic [DATA_W-1:0] bus_o,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] z_o
);
    dp_regs_t regs_d, regs_q;

    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] reg_rdata;
    logic [REG_AW-1:0] fld_rs, fld_rt, fld_rd, reg_idx;
    logic [DATA_W-1:0] imm_val, ofs_val, jmp_val;
    logic [DATA_W-1:0] src_val [SRC_N];
    logic [DATA_W-1:0] src_gated [SRC_N];

    sbd_ir_fields u_fields (
        .ir_i  (regs_q.ir),
        .pc_i  (regs_q.pc),
        .rs_o  (fld_rs),
        .rt_o  (fld_rt),
        .rd_o  (fld_rd),
        .imm_o (imm_val),
        .ofs_o (ofs_val),
        .jmp_o (jmp_val)
    );

    always_comb begin
        unique case (fld_sel_e'(reg_sel))
            FLD_RS:  reg_idx = fld_rs;
            FLD_RT:  reg_idx = fld_rt;
            default: reg_idx = fld_rd;
        endcase
    end

    sbd_regfile #(.W(DATA_W), .CNT(REG_CNT)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (reg_idx),
        .we_i    (ld_reg),
        .wdata_i (bus),
        .rdata_o (reg_rdata)
    );

    sbd_alu #(.W(DATA_W)) u_alu (
        .y_i   (regs_q.y),
        .bus_i (bus),
        .op_i  (alu_op_e'(alu_op)),
        .res_o (alu_res)
    );

    assign src_val[SRC_CONST] = const_val;
    assign src_val[SRC_Y]     = regs_q.y;
    assign src_val[SRC_Z]     = regs_q.z;
    assign src_val[SRC_PC]    = regs_q.pc;
    assign src_val[SRC_REG]   = reg_rdata;
    assign src_val[SRC_IMM]   = imm_val;
    assign src_val[SRC_OFS]   = ofs_val;
    assign src_val[SRC_JMP]   = jmp_val;

    // each source is gated by its own enable, as a bus driver would be
    for (genvar s = 0; s < SRC_N; s++) begin : g_drv
        assign src_gated[s] = src_en[s] ? src_val[s] : '0;
    end

    always_comb begin
        bus = '0;
        for (int s = 0; s < SRC_N; s++) bus = bus | src_gated[s];
    end

    always_comb begin
        regs_d = regs_q;
        if (ld_y)  regs_d.y = bus;
        if (ld_z)  regs_d.z = alu_res;
        if (ld_pc || (ld_pc_z && (regs_q.z == '0))) regs_d.pc = bus;
        if (ld_ir) regs_d.ir = bus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_o = bus;
    assign pc_o  = regs_q.pc;
    assign z_o   = regs_q.z;
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker
    import sbd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  src_en,
    input logic              ld_z,
    input logic              ld_pc,
    input logic              ld_pc_z,
    input logic [REG_AW-1:0] reg_idx,
    input logic [DATA_W-1:0] bus_o,
    input logic [DATA_W-1:0] pc_o,
    input logic [DATA_W-1:0] z_o
);
    // R1
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_en));

    // R1
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0) |-> (bus_o == '0));

    // R6
    z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_z |=> $stable(z_o));

    // R10
    pc_cond_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pc_z && !ld_pc && (z_o != '0)) |=> $stable(pc_o));

    // R10
    pc_cond_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pc_z && (z_o == '0)) |=> (pc_o == $past(bus_o)));

    // R12
    reg_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == SRC_N'(1 << SRC_REG) && reg_idx == '0) |-> (bus_o == '0));
endmodule

bind sbd_top sbd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_en  (src_en),
    .ld_z    (ld_z),
    .ld_pc   (ld_pc),
    .ld_pc_z (ld_pc_z),
    .reg_idx (reg_idx),
    .bus_o   (bus_o),
    .pc_o    (pc_o),
    .z_o     (z_o)
);

// File: tb/sbd_top_test.sv
`timescale 1ns/1ps
module sbd_top_test;
    import sbd_pkg::*;

    localparam int NV = 13;
    // {op, y, bus, expected}
    localparam logic [98:0] VEC [NV] = '{
        {3'd0, 32'd5,          32'd7,          32'd12},
        {3'd0, 32'hFFFFFFFF,   32'd1,          32'd0},
        {3'd7, 32'd10,         32'd3,          32'd7},
        {3'd7, 32'd3,          32'd10,         32'hFFFFFFF9},
        {3'd1, 32'hF0F0F0F0,   32'h0FF00FF0,   32'h00F000F0},
        {3'd3, 32'hF0F0F0F0,   32'h0FF00FF0,   32'hFFF0FFF0},
        {3'd2, 32'hF0F0F0F0,   32'h0FF00FF0,   32'hFF00FF00},
        {3'd4, 32'd4,          32'h00000F01,   32'h0000F010},
        {3'd5, 32'd8,          32'h80000000,   32'h00800000},
        {3'd4, 32'h00000021,   32'd1,          32'd2},
        {3'd6, 32'hFFFFFFFF,   32'd1,          32'd1},
        {3'd6, 32'd5,          32'd5,          32'd0},
        {3'd6, 32'd1,          32'hFFFFFFFF,   32'd0}
    };

    localparam logic [5:0] L_NONE = 6'd0;
    localparam logic [5:0] L_Y    = 6'd1;
    localparam logic [5:0] L_Z    = 6'd2;
    localparam logic [5:0] L_PC   = 6'd4;
    localparam logic [5:0] L_PCZ  = 6'd8;
    localparam logic [5:0] L_IR   = 6'd16;
    localparam logic [5:0] L_REG  = 6'd32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SRC_N-1:0]  src_en = '0;
    logic [5:0]        ld = '0;
    logic [2:0]        alu_op = '0;
    logic [1:0]        reg_sel = '0;
    logic [DATA_W-1:0] const_val = '0;
    logic [DATA_W-1:0] bus_o, pc_o, z_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sbd_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .ld_y      (ld[0]),
        .ld_z      (ld[1]),
        .ld_pc     (ld[2]),
        .ld_pc_z   (ld[3]),
        .ld_ir     (ld[4]),
        .ld_reg    (ld[5]),
        .alu_op    (alu_op),
        .reg_sel   (reg_sel),
        .const_val (const_val),
        .bus_o     (bus_o),
        .pc_o      (pc_o),
        .z_o       (z_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic idle();
        src_en = '0; ld = L_NONE; alu_op = '0; reg_sel = '0; const_val = '0;
    endtask

    // one bus cycle closed by a clock edge
    task automatic drive(int src, logic [5:0] l, logic [2:0] op, logic [1:0] sel,
                         logic [31:0] k);
        src_en = SRC_N'(1 << src); ld = l; alu_op = op; reg_sel = sel; const_val = k;
        @(posedge clk); #1;
        idle();
    endtask

    // look at the bus without a clock edge
    task automatic peek(int src, logic [1:0] sel, output logic [31:0] v);
        src_en = SRC_N'(1 << src); reg_sel = sel;
        #1 v = bus_o;
        idle();
    endtask

    function automatic string req_of(logic [2:0] op);
        case (op)
            3'd0, 3'd7:       return "R2";
            3'd1, 3'd2, 3'd3: return "R3";
            3'd4, 3'd5:       return "R4";
            default:          return "R5";
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R13 reset state
        peek(SRC_PC, 2'd0, v); check("R13 pc", v, 32'd0);
        peek(SRC_Z, 2'd0, v);  check("R13 z", v, 32'd0);
        peek(SRC_Y, 2'd0, v);  check("R13 y", v, 32'd0);
        peek(SRC_REG, 2'd0, v); check("R13 reg", v, 32'd0);
        // R1 no source enabled
        #1 check("R1 idle bus", bus_o, 32'd0);

        // ALU table: load Y, then compute into Z
        for (int i = 0; i < NV; i++) begin
            automatic logic [2:0]  op  = VEC[i][98:96];
            automatic logic [31:0] yv  = VEC[i][95:64];
            automatic logic [31:0] bv  = VEC[i][63:32];
            automatic logic [31:0] ev  = VEC[i][31:0];
            drive(SRC_CONST, L_Y, 3'd0, 2'd0, yv);
            drive(SRC_CONST, L_Z, op, 2'd0, bv);
            peek(SRC_Z, 2'd0, v);
            check(req_of(op), v, ev);
        end

        // R6 Z and Y hold without their strobes
        drive(SRC_CONST, L_Y, 3'd0, 2'd0, 32'd100);
        drive(SRC_CONST, L_Z, 3'd0, 2'd0, 32'd23);
        drive(SRC_CONST, L_NONE, 3'd0, 2'd0, 32'd999);
        check("R6 z hold", z_o, 32'd123);
        peek(SRC_Y, 2'd0, v); check("R6 y hold", v, 32'd100);

        // R7 R8 negative immediate
        drive(SRC_CONST, L_IR, 3'd0, 2'd0, 32'h2000FFFE);
        peek(SRC_IMM, 2'd0, v); check("R7 neg imm", v, 32'hFFFFFFFE);
        peek(SRC_OFS, 2'd0, v); check("R8 neg ofs", v, 32'hFFFFFFF8);
        drive(SRC_CONST, L_IR, 3'd0, 2'd0, 32'h20001234);
        peek(SRC_IMM, 2'd0, v); check("R7 pos imm", v, 32'h00001234);
        peek(SRC_OFS, 2'd0, v); check("R8 pos ofs", v, 32'h000048D0);

        // R9 jump target, R10 unconditional PC load
        drive(SRC_CONST, L_PC, 3'd0, 2'd0, 32'hA4000000);
        check("R10 pc load", pc_o, 32'hA4000000);
        drive(SRC_CONST, L_IR, 3'd0, 2'd0, 32'h0BADBEEF);
        peek(SRC_JMP, 2'd0, v); check("R9 jump", v, 32'hA7ADBEEF);

        // R10 conditional load skipped when Z is nonzero
        drive(SRC_CONST, L_Y, 3'd0, 2'd0, 32'd1);
        drive(SRC_CONST, L_Z, 3'd0, 2'd0, 32'd0);
        drive(SRC_CONST, L_PCZ, 3'd0, 2'd0, 32'h00000100);
        check("R10 cond skip", pc_o, 32'hA4000000);
        // and taken when Z is zero
        drive(SRC_CONST, L_Y, 3'd0, 2'd0, 32'd0);
        drive(SRC_CONST, L_Z, 3'd0, 2'd0, 32'd0);
        drive(SRC_CONST, L_PCZ, 3'd0, 2'd0, 32'h00000200);
        check("R10 cond take", pc_o, 32'h00000200);

        // R11 field selection: rs=3 rt=4 rd=5
        drive(SRC_CONST, L_IR, 3'd0, 2'd0, 32'h00642800);
        drive(SRC_CONST, L_REG, 3'd0, 2'd2, 32'hCAFE0001);
        drive(SRC_CONST, L_REG, 3'd0, 2'd1, 32'h00000011);
        peek(SRC_REG, 2'd1, v); check("R11 rt read", v, 32'h00000011);
        peek(SRC_REG, 2'd3, v); check("R11 rd read code3", v, 32'hCAFE0001);
        drive(SRC_CONST, L_IR, 3'd0, 2'd0, 32'h00A00000);
        peek(SRC_REG, 2'd0, v); check("R11 rs read", v, 32'hCAFE0001);

        // R12 entry 0 ignores writes
        drive(SRC_CONST, L_IR, 3'd0, 2'd0, 32'h00000000);
        drive(SRC_CONST, L_REG, 3'd0, 2'd2, 32'h0000FFFF);
        peek(SRC_REG, 2'd0, v); check("R12 r0 zero", v, 32'd0);

        // R1 bus back to zero with nothing enabled
        #1 check("R1 idle bus end", bus_o, 32'd0);

        done = 1'b1;
        summary();
    end
endmodule